// File: doc/BRIEF.md
# Two-Phase Stepper Position Sequencer

This block moves a two-phase stepper motor toward a commanded position, using eight sub-steps per electrical cycle. Software, or any bus bridge, writes two 32-bit words through a plain write port. One word is a speed divider and the other is a position reference. An internal tick generator divides the clock by the speed value to pace the motion.

On every tick the sequencer compares the reference with its own position counter and makes one decision:

- It takes one sub-step forward when the sign bit of (reference − position) is clear.
- It takes one sub-step backward when that sign bit is set.
- It holds when the two values are equal.

The current sub-step is decoded into registered gate enables for the four transistors of each phase's full bridge.

Typical use: write a nonzero speed once, then write new position targets. The motor walks to each target and holds there with the coils energised in the last sub-step pattern.

Top module: `stepseq_top`

## Requirements
- R1: During and after reset the sub-step is 0, and the outputs are gate_a = 4'b0000 and gate_b = 4'b0110.
- R2: Each gate vector is packed {right-low, right-high, left-low, left-high}. Left-high and left-low for the sub-steps are as follows:
  - sub-step 0: phase B left-low.
  - sub-step 1: A left-high and B left-low.
  - sub-step 2: A left-high.
  - sub-step 3: A left-high and B left-high.
  - sub-step 4: B left-high.
  - sub-step 5: A left-low and B left-high.
  - sub-step 6: A left-low.
  - sub-step 7: A left-low and B left-low.
  - Every other left gate is 0.
- R3: In each phase, right-low (bit 3) always equals left-high (bit 0), and right-high (bit 2) always equals left-low (bit 1).
- R4: On a tick where the reference differs from the position and bit 31 of (reference − position) is 0, the sub-step advances by one modulo 8 and the position increments.
- R5: On a tick where bit 31 of (reference − position) is 1, the sub-step goes back by one modulo 8 and the position decrements. A negative two's-complement reference therefore drives the motor backward past zero.
- R6: When the position equals the reference, ticks cause no step and the outputs stay constant.
- R7: With speed value N ≥ 1, consecutive steps of one move are exactly N clock cycles apart.
- R8: A speed value of 0 stops all stepping, even when the position differs from the reference.
- R9: A write with wr_en high loads wr_data into the speed register at word address 0 and into the position reference at word address 1. The new value takes effect from the following cycle.
- R10: A single step changes the sub-step by exactly one, in either direction, and never by more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (1) | Word address: 0 speed, 1 position reference |
| wr_data | input | DATA_W (32) | Write data |
| gate_a | output | 4 | Phase A gate enables {right-low, right-high, left-low, left-high} |
| gate_b | output | 4 | Phase B gate enables, same packing |

## Verification
The assertions assume that reset is held for at least one clock and that wr_addr only carries the two defined word addresses. They also assume that the reference moves only by amounts that keep reference − position inside the signed 32-bit range. Otherwise the sign test would choose the long way round.

The stimulus meets these assumptions as follows:
- Each move target is written only after the speed register is settled.
- Every target lies within a few dozen steps of the current position, including targets just below zero.
- The disabled-speed case is entered and left by register writes only.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

  localparam int unsigned SUBSTEPS = 8;
  localparam int unsigned SS_W     = $clog2(SUBSTEPS);

  typedef logic [SS_W-1:0] substep_t;

  // Left-leg gates of both phases for a sub-step:
  // {B left-low, B left-high, A left-low, A left-high}
  function automatic logic [3:0] left_gates(input substep_t s);
    logic [3:0] g;
    case (s)
      3'd0:    g = 4'b1000;
      3'd1:    g = 4'b1001;
      3'd2:    g = 4'b0001;
      3'd3:    g = 4'b0101;
      3'd4:    g = 4'b0100;
      3'd5:    g = 4'b0110;
      3'd6:    g = 4'b0010;
      default: g = 4'b1010;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/stepseq_regs.sv
module stepseq_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] speed_q,
  output logic [DATA_W-1:0] target_q
);

  localparam logic [ADDR_W-1:0] ADDR_SPEED  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_TARGET = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      speed_q  <= '0;
      target_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_SPEED)  speed_q  <= wr_data;
      if (wr_addr == ADDR_TARGET) target_q <= wr_data;
    end
  end

  assert_speed_load_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_SPEED) |=> (speed_q == $past(wr_data)));

  assert_target_load_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_TARGET) |=> (target_q == $past(wr_data)));

endmodule

// File: rtl/stepseq_tick.sv
module stepseq_tick #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] period_i,
  output logic              tick_o
);

  logic [DATA_W-1:0] cnt_q;
  logic              wrap;

  assign wrap = (cnt_q >= period_i - DATA_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (period_i == '0) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + DATA_W'(1);
      tick_o <= 1'b0;
    end
  end

  assert_zero_speed_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (period_i == '0) |=> !tick_o);

  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    (tick_o && period_i > DATA_W'(1) && $stable(period_i)) |=> !tick_o);

endmodule

// File: rtl/stepseq_core.sv
module stepseq_core
  import stepseq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] target_i,
  output substep_t          substep_o
);

  logic [DATA_W-1:0] pos_q;
  logic [DATA_W-1:0] gap;
  logic              at_target;
  logic              go_back;

  assign gap       = target_i - pos_q;
  assign at_target = (gap == '0);
  assign go_back   = gap[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      substep_o <= '0;
      pos_q     <= '0;
    end else if (tick_i && !at_target) begin
      if (go_back) begin
        substep_o <= substep_o - substep_t'(1);
        pos_q     <= pos_q - DATA_W'(1);
      end else begin
        substep_o <= substep_o + substep_t'(1);
        pos_q     <= pos_q + DATA_W'(1);
      end
    end
  end

  assert_hold_at_target_R6: assert property (@(posedge clk) disable iff (rst)
    (tick_i && target_i == pos_q) |=> $stable(substep_o));

  assert_forward_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && target_i != pos_q && !go_back) |=> (substep_o == $past(substep_o) + substep_t'(1)));

  assert_backward_step_R5: assert property (@(posedge clk) disable iff (rst)
    (tick_i && go_back) |=> (substep_o == $past(substep_o) - substep_t'(1)));

  assert_single_step_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(substep_o) |-> ((substep_o == $past(substep_o) + substep_t'(1)) ||
                             (substep_o == $past(substep_o) - substep_t'(1))));

  assert_idle_without_tick_R8: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(substep_o));

endmodule

// File: rtl/stepseq_gates.sv
module stepseq_gates
  import stepseq_pkg::*;
#(
  parameter int unsigned PHASES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  substep_t               substep_i,
  output logic [PHASES*4-1:0]    gates_o
);

  localparam int unsigned LEFT_W = PHASES * 2;

  logic [LEFT_W-1:0] left_now;
  logic [LEFT_W-1:0] left_rst;

  assign left_now = LEFT_W'(left_gates(substep_i));
  assign left_rst = LEFT_W'(left_gates('0));

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    logic hi_n, lo_n, hi_r, lo_r;
    assign hi_n = left_now[2*p];
    assign lo_n = left_now[2*p+1];
    assign hi_r = left_rst[2*p];
    assign lo_r = left_rst[2*p+1];

    // {right-low, right-high, left-low, left-high}
    always_ff @(posedge clk) begin
      if (rst) gates_o[4*p +: 4] <= {hi_r, lo_r, lo_r, hi_r};
      else     gates_o[4*p +: 4] <= {hi_n, lo_n, lo_n, hi_n};
    end

    assert_leg_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
      !(gates_o[4*p] && gates_o[4*p+1]));
  end

endmodule

// File: rtl/stepseq_top.sv
module stepseq_top
  import stepseq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [3:0]        gate_a,
  output logic [3:0]        gate_b
);

  localparam int unsigned PHASES = 2;

  logic [DATA_W-1:0]   speed_q;
  logic [DATA_W-1:0]   target_q;
  logic                tick;
  substep_t            substep;
  logic [PHASES*4-1:0] gates;

  stepseq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .speed_q(speed_q), .target_q(target_q));

  stepseq_tick #(.DATA_W(DATA_W)) u_tick (
    .clk(clk), .rst(rst), .period_i(speed_q), .tick_o(tick));

  stepseq_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .tick_i(tick), .target_i(target_q), .substep_o(substep));

  stepseq_gates #(.PHASES(PHASES)) u_gates (
    .clk(clk), .rst(rst), .substep_i(substep), .gates_o(gates));

  assign gate_a = gates[3:0];
  assign gate_b = gates[7:4];

  assert_mirror_R3: assert property (@(posedge clk) disable iff (rst)
    (gate_a[3] == gate_a[0]) && (gate_a[2] == gate_a[1]) &&
    (gate_b[3] == gate_b[0]) && (gate_b[2] == gate_b[1]));

endmodule

// File: tb/sim_stepseq_top.sv
module sim_stepseq_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  gate_a, gate_b;

  always #2 clk = ~clk;  // 250 MHz

  stepseq_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gate_a(gate_a), .gate_b(gate_b));

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  logic [7:0]  expq[$];
  int          m_sub = 0;
  logic [31:0] m_pos = '0;
  int          exp_gap = 0;
  bit          gap_armed = 1'b0;
  bit          mon_on = 1'b0;
  int          since = 0;
  logic [7:0]  last_seen = '0;

  // Expected {gate_b, gate_a} for a sub-step, from R2/R3.
  function automatic logic [7:0] pat(input int s);
    logic ah, al, bh, bl;
    ah = (s == 1) || (s == 2) || (s == 3);
    al = (s == 5) || (s == 6) || (s == 7);
    bh = (s == 3) || (s == 4) || (s == 5);
    bl = (s == 7) || (s == 0) || (s == 1);
    return {bh, bl, bl, bh, ah, al, al, ah};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: each output change pops one expected pattern and checks spacing.
  always @(negedge clk) begin
    if (mon_on) begin
      since++;
      if ({gate_b, gate_a} !== last_seen) begin
        if (expq.size() == 0) begin
          check("R6 unexpected step", {24'd0, gate_b, gate_a}, {24'd0, last_seen});
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          check("R2/R4/R5 step pattern", {24'd0, gate_b, gate_a}, {24'd0, e});
          if (gap_armed) check("R7 step interval", since, exp_gap);
        end
        gap_armed = 1'b1;
        since = 0;
        last_seen = {gate_b, gate_a};
      end
    end
  end

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: predict the whole move into the scoreboard.
  task automatic plan(input logic [31:0] tgt);
    logic [31:0] d;
    for (int k = 0; k < 1000 && m_pos != tgt; k++) begin
      d = tgt - m_pos;
      if (d[31]) begin m_sub = (m_sub + 7) % 8; m_pos = m_pos - 1; end
      else       begin m_sub = (m_sub + 1) % 8; m_pos = m_pos + 1; end
      expq.push_back(pat(m_sub));
    end
  endtask

  task automatic settle(input string req);
    int k;
    k = 0;
    while (expq.size() != 0 && k < 5000) begin @(negedge clk); k++; end
    check({req, " move completes"}, expq.size(), 0);
    repeat (3 * (exp_gap + 2)) @(negedge clk);
    check({req, " R6 hold pattern"}, {24'd0, gate_b, gate_a}, {24'd0, pat(m_sub)});
  endtask

  task automatic move(input int spd, input logic [31:0] tgt, input string req);
    exp_gap = spd;
    wr(1'b0, spd);
    gap_armed = 1'b0;
    plan(tgt);
    wr(1'b1, tgt);
    settle(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset gate_a", gate_a, 4'b0000);
    check("R1 reset gate_b", gate_b, 4'b0110);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {gate_b, gate_a}, {24'd0, pat(0)});
    last_seen = {gate_b, gate_a};
    mon_on = 1'b1;

    move(4, 32'd5, "R4 forward N=4");
    move(4, 32'd13, "R2 wrap through 7->0");
    move(2, 32'hFFFF_FFFD, "R5 backward past zero");
    move(1, 32'h0000_0002, "R7 N=1 forward");

    // R8: zero speed keeps the outputs still, although the target moved away.
    wr(1'b0, 32'd0);
    wr(1'b1, 32'd9);
    repeat (60) @(negedge clk);
    check("R8 no step at speed 0", {gate_b, gate_a}, {24'd0, pat(m_sub)});
    check("R8 scoreboard untouched", expq.size(), 0);
    exp_gap = 3;
    gap_armed = 1'b0;
    plan(32'd9);
    wr(1'b0, 32'd3);
    settle("R9 speed reg restarts stepping");

    // R6: rewriting the same target causes no motion.
    wr(1'b1, 32'd9);
    repeat (40) @(negedge clk);
    check("R6 same target idle", {gate_b, gate_a}, {24'd0, pat(m_sub)});

    move(5, 32'd1, "R10 backward N=5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule